// File: doc/BRIEF.md
# Nine-Sample Median Selection Network

This block returns the median of nine unsigned samples. It is a fixed network of single minimum and maximum elements. The order of the comparisons never depends on the sample values. First, each group of three samples is fully ordered. Next, the network takes the largest of the three group minima, the median of the three group middles and the smallest of the three group maxima. Last, it returns the median of those three values. Every element whose result cannot reach the output has been removed. This leaves 30 two-input elements in nine layers. A network that sorts all nine samples and then taps the middle position needs more elements than this.

Sample sets enter on a valid/ready stream and medians leave on a second valid/ready stream. The parameter `PIPE_MASK` can place a register after any of the nine layers. The latency is the number of set bits in the mask. All registered layers advance together whenever the output slot is empty or being taken. So back-pressure from the sink reaches `in_ready` in the same cycle. A transfer happens on a rising clock edge where valid and ready are both high. A source must hold its data steady while its valid is high and ready is low.

Top module: `med9_net`

## Requirements
- R1: When a result is taken, `out_median` equals the fifth smallest of the nine unsigned samples of the matching input set. Sample k sits at `in_samples[k*W +: W]`.
- R2: Repeated values in a set are handled correctly. If all nine samples are equal, the output is that value. Mixed groups of equal values give the fifth smallest value of the multiset.
- R3: The output is correct for all 512 sets whose samples are each either zero or all-ones.
- R4: Exactly one result leaves for each accepted set, and results leave in the order the sets were accepted. No result appears without a matching accepted set.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_median` keeps its value in the next cycle.
- R6: With LAT = number of ones in `PIPE_MASK`, a set accepted in a cycle with the output side free appears on the output LAT cycles later. At most LAT sets are in flight. If LAT is 0, the network is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.
- R7: After reset (when LAT > 0), `out_valid` is low and `in_ready` is high.
- R8: When LAT > 0, `in_ready` is low in any cycle where `out_valid` is high and `out_ready` is low. A set offered in such a cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input set is offered |
| in_ready | output | 1 | Network accepts a set this cycle |
| in_samples | input | 9*W | Nine unsigned samples, sample k at bits k*W +: W |
| out_valid | output | 1 | A median is offered |
| out_ready | input | 1 | Sink takes the median this cycle |
| out_median | output | W | Median of the set |

## Verification
The hardest cases are those where only a single pruned element decides the result. Examples are a value that must win the three-way comparison at the end, or ties that pass through elements that keep only one side. Random values rarely reach these. The stimulus therefore sends all 512 zero/all-ones sets as well as directed sets with ties, outliers and sorted orders. A stall held over several cycles is also hard to produce when the full pipeline is busy. Random gaps in `out_ready` during back-to-back traffic create many stall cycles. This lets the bench check the held output, the blocked input and the result order against a scoreboard queue.

// File: rtl/med9_pkg.sv
package med9_pkg;
  localparam int NLANE  = 9;
  localparam int NLAYER = 9;
  localparam int MAXOPS = 3;
  localparam int OUT_LANE = 1;

  // One compare slot: min goes to lane lo, max goes to lane hi
  typedef struct packed {
    logic       en;
    logic       kmin;
    logic       kmax;
    logic [3:0] lo;
    logic [3:0] hi;
  } op_t;

  function automatic op_t mk(input int lo, input int hi, input bit kmin, input bit kmax);
    op_t o;
    o.en   = 1'b1;
    o.kmin = kmin;
    o.kmax = kmax;
    o.lo   = 4'(lo);
    o.hi   = 4'(hi);
    return o;
  endfunction

  // Fixed schedule; lanes 0-2, 3-5, 6-8 form three groups
  function automatic op_t sched(input int layer, input int slot);
    op_t o;
    o = '0;
    case (layer * MAXOPS + slot)
      0, 6:  o = mk(0, 1, 1, 1);
      1, 7:  o = mk(3, 4, 1, 1);
      2, 8:  o = mk(6, 7, 1, 1);
      3:     o = mk(1, 2, 1, 1);
      4:     o = mk(4, 5, 1, 1);
      5:     o = mk(7, 8, 1, 1);
      9:     o = mk(3, 0, 0, 1);  // larger of two group minima
      10:    o = mk(1, 4, 1, 1);  // middles
      11:    o = mk(2, 5, 1, 0);  // smaller of two group maxima
      12:    o = mk(6, 0, 0, 1);
      13:    o = mk(4, 7, 1, 0);
      14:    o = mk(2, 8, 1, 0);
      15:    o = mk(4, 1, 0, 1);  // median of middles into lane 1
      18:    o = mk(0, 1, 1, 1);
      21:    o = mk(1, 2, 1, 0);
      24:    o = mk(0, 1, 0, 1);
      default: o = '0;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/med9_elem.sv
module med9_elem #(
  parameter int W      = 8,
  parameter bit IS_MAX = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  generate
    if (IS_MAX) begin : g_max
      assign y = (a > b) ? a : b;
    end else begin : g_min
      assign y = (a < b) ? a : b;
    end
  endgenerate
endmodule

// File: rtl/med9_layer.sv
module med9_layer
  import med9_pkg::*;
#(
  parameter int W     = 8,
  parameter int LAYER = 0
) (
  input  logic [NLANE*W-1:0] d_i,
  output logic [NLANE*W-1:0] d_o
);
  logic [W-1:0] lo_w [MAXOPS];
  logic [W-1:0] hi_w [MAXOPS];

  for (genvar s = 0; s < MAXOPS; s++) begin : g_slot
    localparam op_t OP = sched(LAYER, s);
    localparam int LO = int'(OP.lo);
    localparam int HI = int'(OP.hi);
    if (OP.en && OP.kmin) begin : g_min
      med9_elem #(.W(W), .IS_MAX(1'b0)) u_min (
        .a(d_i[LO*W +: W]), .b(d_i[HI*W +: W]), .y(lo_w[s]));
    end else begin : g_nomin
      assign lo_w[s] = '0;
    end
    if (OP.en && OP.kmax) begin : g_max
      med9_elem #(.W(W), .IS_MAX(1'b1)) u_max (
        .a(d_i[LO*W +: W]), .b(d_i[HI*W +: W]), .y(hi_w[s]));
    end else begin : g_nomax
      assign hi_w[s] = '0;
    end
  end

  always_comb begin
    d_o = d_i;
    for (int s = 0; s < MAXOPS; s++) begin
      if (sched(LAYER, s).en && sched(LAYER, s).kmin)
        d_o[int'(sched(LAYER, s).lo)*W +: W] = lo_w[s];
      if (sched(LAYER, s).en && sched(LAYER, s).kmax)
        d_o[int'(sched(LAYER, s).hi)*W +: W] = hi_w[s];
    end
  end
endmodule

// File: rtl/med9_stage.sv
module med9_stage #(
  parameter int DW  = 72,
  parameter bit REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          v_i,
  input  logic [DW-1:0] d_i,
  output logic          v_o,
  output logic [DW-1:0] d_o
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)   v_o <= 1'b0;
        else if (adv) v_o <= v_i;
      end
      always_ff @(posedge clk) begin
        if (adv) d_o <= d_i;
      end
    end else begin : g_wire
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, adv};
      assign v_o = v_i;
      assign d_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/med9_net.sv
module med9_net
  import med9_pkg::*;
#(
  parameter int               W         = 8,
  parameter logic [NLAYER-1:0] PIPE_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [9*W-1:0]   in_samples,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_median
);
  localparam int DW  = NLANE * W;
  localparam int LAT = $countones(PIPE_MASK);

  logic [DW-1:0] lane_d [NLAYER+1];
  logic          lane_v [NLAYER+1];
  logic [DW-1:0] comb_d [NLAYER];
  logic          adv;

  generate
    if (LAT > 0) begin : g_adv_reg
      assign adv = !lane_v[NLAYER] || out_ready;
    end else begin : g_adv_comb
      assign adv = out_ready;
    end
  endgenerate

  assign in_ready  = adv;
  assign lane_d[0] = in_samples;
  assign lane_v[0] = in_valid;

  for (genvar l = 0; l < NLAYER; l++) begin : g_layer
    med9_layer #(.W(W), .LAYER(l)) u_layer (
      .d_i(lane_d[l]), .d_o(comb_d[l]));
    med9_stage #(.DW(DW), .REG(PIPE_MASK[l])) u_stage (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .v_i(lane_v[l]), .d_i(comb_d[l]),
      .v_o(lane_v[l+1]), .d_o(lane_d[l+1]));
  end

  assign out_valid  = lane_v[NLAYER];
  assign out_median = lane_d[NLAYER][OUT_LANE*W +: W];
endmodule

// File: rtl/med9_net_chk.sv
module med9_net_chk #(
  parameter int W   = 8,
  parameter int LAT = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_median
);
  localparam int CW = $clog2(LAT + 2);

  generate
    if (LAT > 0) begin : g_seq
      logic [CW-1:0] inflight;
      always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else inflight <= inflight + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);
      end

      assert_hold_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);
      assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_median));
      assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
      assert_reset_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));
      assert_inflight_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(inflight) <= LAT);
    end else begin : g_comb
      logic unused_ok;
      assign unused_ok = &{1'b0, out_median};
      assert_comb_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      assert_comb_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == out_ready);
    end
  endgenerate
endmodule

bind med9_net med9_net_chk #(.W(W), .LAT($countones(PIPE_MASK))) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_median(out_median));

// File: tb/med9_net_bench.sv
`timescale 1ns/1ps
module med9_net_bench;
  localparam int W = 8;
  localparam logic [8:0] PIPE_MASK = 9'h1FF;
  localparam int LAT = $countones(PIPE_MASK);
  localparam logic [W-1:0] TOP = '1;

  typedef struct { logic [W-1:0] m; string tag; } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [9*W-1:0] in_samples = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [W-1:0] out_median;

  int total = 0, bad = 0;
  int cyc = 0, sent = 0, got = 0;
  int acc_cyc = 0, out_cyc = 0;
  bit stall_on = 0, finished = 0, pend = 0;
  logic [W-1:0] held;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  med9_net #(.W(W), .PIPE_MASK(PIPE_MASK)) u_med9_net (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .out_valid(out_valid), .out_ready(out_ready),
    .out_median(out_median));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [W-1:0] ref_median(input logic [9*W-1:0] v);
    logic [W-1:0] a [9];
    logic [W-1:0] t;
    for (int i = 0; i < 9; i++) a[i] = v[i*W +: W];
    for (int i = 1; i < 9; i++)
      for (int j = i; j > 0 && a[j-1] > a[j]; j--) begin
        t = a[j]; a[j] = a[j-1]; a[j-1] = t;
      end
    return a[4];
  endfunction

  task automatic send(input logic [9*W-1:0] v, input string tag);
    exp_t e;
    e.m = ref_median(v);
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    in_valid = 1;
    in_samples = v;
    do @(negedge clk); while (!in_ready);
    acc_cyc = cyc;
    sent++;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // sink back-pressure
  always @(posedge clk) begin
    #1;
    if (stall_on) out_ready = ($urandom_range(0, 9) < 6);
    else out_ready = 1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (pend) begin
        chk(out_valid == 1'b1, "R5", int'(out_valid), 1);
        chk(out_median == held, "R5", int'(out_median), int'(held));
        pend = 0;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", int'(out_median), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(out_median == e.m, e.tag, int'(out_median), int'(e.m));
          got++;
          out_cyc = cyc;
        end
      end else if (out_valid && !out_ready) begin
        pend = 1;
        held = out_median;
        if (LAT > 0) chk(!in_ready, "R8", int'(in_ready), 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [9*W-1:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R7: empty after reset
    chk(out_valid == 1'b0, "R7", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R7", int'(in_ready), 1);

    // R6: latency on an idle pipeline with free output
    for (int i = 0; i < 9; i++) v[i*W +: W] = W'(9 - i);
    send(v, "R1");
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    chk(out_cyc - acc_cyc == LAT, "R6", out_cyc - acc_cyc, LAT);

    // R2: ties
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 9; i++) v[i*W +: W] = (k == 0) ? '0 : (k == 1) ? TOP : W'(77);
      send(v, "R2");
    end
    for (int i = 0; i < 9; i++) v[i*W +: W] = (i % 2 == 0) ? W'(10) : W'(200);
    send(v, "R2");
    for (int i = 0; i < 9; i++) v[i*W +: W] = (i < 4) ? W'(3) : W'(9);
    send(v, "R2");
    for (int i = 0; i < 9; i++) v[i*W +: W] = (i < 5) ? W'(50) : W'(40);
    send(v, "R2");

    // R1: sorted, reversed, outlier
    for (int i = 0; i < 9; i++) v[i*W +: W] = W'(i * 20);
    send(v, "R1");
    for (int i = 0; i < 9; i++) v[i*W +: W] = W'(240 - i * 25);
    send(v, "R1");
    for (int i = 0; i < 9; i++) v[i*W +: W] = (i == 4) ? TOP : W'(i + 1);
    send(v, "R1");
    idle();

    // R3: every zero/all-ones set, with sink stalls
    stall_on = 1;
    for (int p = 0; p < 512; p++) begin
      for (int i = 0; i < 9; i++) v[i*W +: W] = p[i] ? TOP : '0;
      send(v, "R3");
    end

    // R1: random sets under back-pressure
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < 9; i++) v[i*W +: W] = W'($urandom_range(0, (1 << W) - 1));
      send(v, "R1");
      if (n % 37 == 0) idle();
    end
    idle();

    while (exp_q.size() != 0) @(negedge clk);
    stall_on = 0;
    repeat (20) @(negedge clk);
    // R4: one result per accepted set
    chk(got == sent, "R4", got, sent);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule